// File: doc/BRIEF.md
# Cross-Product FM Discriminator

This block turns a stream of filtered complex baseband samples into the modulating signal of an FM carrier. It does not extract the phase with an arctangent or a rotation engine. For each accepted sample it takes the in-phase and quadrature rails together with the pair accepted one sample earlier and forms the cross product of the present sample with the sample-to-sample change. That quantity is proportional to the phase step between the two samples, scaled by the squared amplitude, so it follows the instantaneous frequency deviation. The intended sample rate is the 400 kHz rate left after decimation, and a 5 kHz audio tone on the carrier appears as a 5 kHz waveform at the output.

Samples arrive with a one-cycle valid strobe, and any gap between strobes is allowed. The block holds one sample of history on each rail and runs a three-stage pipeline: difference, multiply, then subtract, round and saturate. It emits one output strobe for each input strobe. The first result after reset is built against zeroed history and carries a marker flag, so the consumer can drop it.

Top module: `fm_xprod_discriminator`

## Requirements
- R1: For each accepted sample (I, Q) with held history (Ip, Qp), the raw value is y = I·(Q − Qp) − Q·(I − Ip), computed exactly. The output is floor((y + 2^14) / 2^15), the round-half-up result for the default shift of 15, before saturation.
- R2: The held history changes only on cycles where `in_valid` is 1. Values on `in_i`/`in_q` while `in_valid` is 0 have no effect on any later output.
- R3: When a sample equals the previously accepted sample on both rails, the output is exactly 0.
- R4: The history is zero after reset. The first output after reset has `out_first` = 1, and every later output has `out_first` = 0.
- R5: `out_valid` is 1 exactly three clock cycles after each cycle with `in_valid` = 1 and is 0 otherwise. Back-to-back input strobes give back-to-back output strobes.
- R6: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768. `out_data` is two's complement.
- R7: While reset is asserted and after it is released, before any input, `out_valid`, `out_first` and `out_data` are all 0.
- R8: A constant-amplitude carrier whose frequency deviation follows a 5 kHz sine at a 400 kHz sample rate gives an output whose sign follows the sign of that sine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Demodulated value, signed |
| out_first | output | 1 | Marks the first output after reset, whose history was zero |

## Verification
The bench drives random values on the sample inputs during idle cycles and then repeats the last accepted sample. A design that latches history without the strobe gives a non-zero result there instead of exactly zero. Two steps are chosen to push the raw cross product past full scale in each direction, so a design that wraps instead of clamping flips the sign of the output. A streamed burst and a mid-run reset check that outputs stay three cycles behind their inputs without merging or being lost, and that the first-output marker comes back after reset. A 5 kHz swept carrier checks the output polarity, which catches swapped rails or a reversed subtraction.

// File: rtl/fmxd_pkg.sv
package fmxd_pkg;

   // Rounding applied when the wide cross-product is scaled down to the output width.
   typedef enum logic {
      FMXD_TRUNCATE = 1'b0,
      FMXD_ROUND_UP = 1'b1
   } fmxd_round_e;

   localparam int unsigned FMXD_DEF_IN_W  = 16;
   localparam int unsigned FMXD_DEF_OUT_W = 16;
   localparam int unsigned FMXD_DEF_SHIFT = 15;

endpackage

// File: rtl/fmxd_delay_diff.sv
module fmxd_delay_diff #(
   parameter int unsigned IN_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_i,
   input  logic signed [IN_W-1:0]   in_q,
   output logic                     s1_valid,
   output logic                     s1_first,
   output logic signed [IN_W-1:0]   s1_i,
   output logic signed [IN_W-1:0]   s1_q,
   output logic signed [IN_W:0]     s1_di,
   output logic signed [IN_W:0]     s1_dq
);

   localparam int unsigned DIFF_W = IN_W + 1;

   logic signed [IN_W-1:0] hist_i;
   logic signed [IN_W-1:0] hist_q;
   logic                   primed;
   logic signed [DIFF_W-1:0] step_i;
   logic signed [DIFF_W-1:0] step_q;

   // Subtraction one bit wider than the operands, so no step can wrap.
   always_comb begin
      step_i = DIFF_W'(in_i) - DIFF_W'(hist_i);
      step_q = DIFF_W'(in_q) - DIFF_W'(hist_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_i   <= '0;
         hist_q   <= '0;
         primed   <= 1'b0;
         s1_valid <= 1'b0;
         s1_first <= 1'b0;
         s1_i     <= '0;
         s1_q     <= '0;
         s1_di    <= '0;
         s1_dq    <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_i     <= in_i;
            s1_q     <= in_q;
            s1_di    <= step_i;
            s1_dq    <= step_q;
            s1_first <= !primed;
            hist_i   <= in_i;
            hist_q   <= in_q;
            primed   <= 1'b1;
         end
      end
   end

   // R2: history moves only with the input strobe
   a_r2_hist_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(hist_i) && $stable(hist_q)));

   // R4: once a sample has been taken, later stage outputs are never marked first
   a_r4_first_once : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && primed) |=> !s1_first);

endmodule

// File: rtl/fmxd_cross_mult.sv
module fmxd_cross_mult #(
   parameter int unsigned IN_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         s1_valid,
   input  logic                         s1_first,
   input  logic signed [IN_W-1:0]       s1_i,
   input  logic signed [IN_W-1:0]       s1_q,
   input  logic signed [IN_W:0]         s1_di,
   input  logic signed [IN_W:0]         s1_dq,
   output logic                         s2_valid,
   output logic                         s2_first,
   output logic signed [2*IN_W+1:0]     s2_pa,
   output logic signed [2*IN_W+1:0]     s2_pb
);

   localparam int unsigned PROD_W = 2 * IN_W + 2;

   logic signed [PROD_W-1:0] cross_a;
   logic signed [PROD_W-1:0] cross_b;

   always_comb begin
      cross_a = PROD_W'(s1_i) * PROD_W'(s1_dq);
      cross_b = PROD_W'(s1_q) * PROD_W'(s1_di);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_first <= 1'b0;
         s2_pa    <= '0;
         s2_pb    <= '0;
      end else begin
         s2_valid <= s1_valid;
         s2_first <= s1_first & s1_valid;
         if (s1_valid) begin
            s2_pa <= cross_a;
            s2_pb <= cross_b;
         end
      end
   end

   // R3: zero step on both rails yields equal (zero) products one stage later
   a_r3_zero_step : assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_di == '0 && s1_dq == '0) |=> (s2_pa == '0 && s2_pb == '0));

endmodule

// File: rtl/fmxd_round_sat.sv
module fmxd_round_sat
   import fmxd_pkg::*;
#(
   parameter int unsigned  PROD_W = 34,
   parameter int unsigned  OUT_W  = 16,
   parameter int unsigned  SHIFT  = 15,
   parameter fmxd_round_e  RMODE  = FMXD_ROUND_UP
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s2_valid,
   input  logic                      s2_first,
   input  logic signed [PROD_W-1:0]  s2_pa,
   input  logic signed [PROD_W-1:0]  s2_pb,
   output logic                      out_valid,
   output logic                      out_first,
   output logic signed [OUT_W-1:0]   out_data
);

   localparam int unsigned SUM_W = PROD_W + 1;
   localparam logic signed [SUM_W-1:0] TOP_V = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] BOT_V = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   if (OUT_W < 2) begin : g_chk_out
      $error("fmxd_round_sat: OUT_W must be at least 2");
   end
   if (SHIFT >= SUM_W - 1) begin : g_chk_shift
      $error("fmxd_round_sat: SHIFT leaves no integer bits");
   end
   if (OUT_W > SUM_W) begin : g_chk_w
      $error("fmxd_round_sat: OUT_W wider than the raw sum");
   end

   logic signed [SUM_W-1:0] raw;
   logic signed [SUM_W-1:0] biased;
   logic signed [SUM_W-1:0] scaled;
   logic signed [SUM_W-1:0] clamped;

   always_comb raw = SUM_W'(s2_pa) - SUM_W'(s2_pb);

   // Rounding variant chosen at elaboration; zero shift needs no bias.
   if (RMODE == FMXD_ROUND_UP && SHIFT > 0) begin : g_round
      localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (SHIFT - 1);
      always_comb biased = raw + HALF;
   end else begin : g_trunc
      always_comb biased = raw;
   end

   always_comb begin
      scaled = biased >>> SHIFT;
      if (scaled > TOP_V)      clamped = TOP_V;
      else if (scaled < BOT_V) clamped = BOT_V;
      else                     clamped = scaled;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s2_valid;
         out_first <= s2_first & s2_valid;
         if (s2_valid) out_data <= clamped[OUT_W-1:0];
      end
   end

   // R6: clamping and rounding never invert the sign of a large raw value
   a_r6_sign_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && raw > SUM_W'(1) <<< SHIFT) |=> !out_data[OUT_W-1]);

   a_r6_neg_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && raw < -(SUM_W'(1) <<< SHIFT)) |=> out_data[OUT_W-1]);

   // R4: the marker never appears without a strobe
   a_r4_first_has_valid : assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid);

endmodule

// File: rtl/fm_xprod_discriminator.sv
module fm_xprod_discriminator
   import fmxd_pkg::*;
#(
   parameter int unsigned IN_W  = FMXD_DEF_IN_W,
   parameter int unsigned OUT_W = FMXD_DEF_OUT_W,
   parameter int unsigned SHIFT = FMXD_DEF_SHIFT,
   parameter fmxd_round_e RMODE = FMXD_ROUND_UP
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_i,
   input  logic signed [IN_W-1:0]  in_q,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_data,
   output logic                    out_first
);

   localparam int unsigned DIFF_W = IN_W + 1;
   localparam int unsigned PROD_W = IN_W + DIFF_W + 1;

   if (IN_W < 2) begin : g_chk_in
      $error("fm_xprod_discriminator: IN_W must be at least 2");
   end

   logic                     s1_valid, s1_first;
   logic signed [IN_W-1:0]   s1_i, s1_q;
   logic signed [DIFF_W-1:0] s1_di, s1_dq;
   logic                     s2_valid, s2_first;
   logic signed [PROD_W-1:0] s2_pa, s2_pb;

   fmxd_delay_diff #(.IN_W(IN_W)) u_diff (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .s1_valid(s1_valid), .s1_first(s1_first), .s1_i(s1_i), .s1_q(s1_q),
      .s1_di(s1_di), .s1_dq(s1_dq)
   );

   fmxd_cross_mult #(.IN_W(IN_W)) u_mult (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_first(s1_first),
      .s1_i(s1_i), .s1_q(s1_q), .s1_di(s1_di), .s1_dq(s1_dq),
      .s2_valid(s2_valid), .s2_first(s2_first), .s2_pa(s2_pa), .s2_pb(s2_pb)
   );

   fmxd_round_sat #(.PROD_W(PROD_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .RMODE(RMODE)) u_rsat (
      .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_first(s2_first),
      .s2_pa(s2_pa), .s2_pb(s2_pb),
      .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
   );

   // Edge count since reset release, so the latency check never reaches before reset.
   logic [1:0] settle;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              settle <= '0;
      else if (settle != 2'd3) settle <= settle + 2'd1;
   end

   // R5: output strobe trails the input strobe by exactly three cycles
   a_r5_latency : assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R3: a repeated sample gives an exact zero two edges after stage one sees it
   a_r3_const_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_di == '0 && s1_dq == '0) |=> ##1 (out_valid && out_data == '0));

endmodule

// File: tb/fm_xprod_discriminator_test.sv
`timescale 1ns/1ps
module fm_xprod_discriminator_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_i = '0;
   logic signed [15:0] in_q = '0;
   logic               out_valid;
   logic signed [15:0] out_data;
   logic               out_first;

   int n_run = 0;
   int n_bad = 0;
   bit finished = 0;

   longint hp_i = 0, hp_q = 0;   // bench copy of accepted history
   bit     exp_first = 1;

   always #2 clk = ~clk;

   fm_xprod_discriminator uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .out_data(out_data), .out_first(out_first)
   );

   localparam int NV = 11;
   localparam logic [31:0] VEC [NV] = '{
      {16'sd1000,   16'sd2000},
      {16'sd1000,   16'sd2000},
      {16'sd20000,  16'sd0},
      {16'sd19000,  16'sd6000},
      {16'sd32767,  16'sd0},
      {16'sd0,      16'sd32767},
      {16'sd32767,  16'sd32767},
      {-16'sd32768, 16'sd32767},
      {16'sd32767,  16'sd32767},
      {-16'sd3,     16'sd5},
      {-16'sd3,     16'sd5}
   };

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected output from the requirements (R1, R6); advances the bench history.
   task automatic model(input longint i, input longint q, output longint r);
      longint y;
      y = i * (q - hp_q) - q * (i - hp_i);
      r = (y + 16384) >>> 15;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      hp_i = i;
      hp_q = q;
   endtask

   // One sample, idle cycles with random junk on the data pins, then check.
   task automatic send(input longint i, input longint q, input string req, output longint got);
      longint e;
      model(i, q, e);
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
      @(negedge clk);
      in_valid = 1'b0; in_i = 16'($urandom); in_q = 16'($urandom);
      check("R5 no early strobe", longint'(out_valid), 0);
      @(negedge clk);
      in_i = 16'($urandom); in_q = 16'($urandom);
      check("R5 no early strobe", longint'(out_valid), 0);
      @(negedge clk);
      check("R5 strobe at 3 cycles", longint'(out_valid), 1);
      check(req, longint'(out_data), e);
      check("R4 first marker", longint'(out_first), longint'(exp_first));
      exp_first = 0;
      got = longint'(out_data);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check("R7 reset valid", longint'(out_valid), 0);
      check("R7 reset data", longint'(out_data), 0);
      check("R7 reset first", longint'(out_first), 0);
      rst_n = 1'b1;
      hp_i = 0; hp_q = 0; exp_first = 1;
      @(negedge clk);
      check("R7 idle after reset", longint'(out_valid), 0);
   endtask

   initial begin
      longint got;
      longint exps [3];
      longint sv_i [3];
      longint sv_q [3];
      real ph;
      real m;
      repeat (3) @(negedge clk);
      check("R7 reset valid", longint'(out_valid), 0);
      check("R7 reset data", longint'(out_data), 0);
      check("R7 reset first", longint'(out_first), 0);
      rst_n = 1'b1;

      // Vector table: R1 main, R3 repeats, R6 clamps, R2 junk between strobes
      for (int k = 0; k < NV; k++) begin
         send(longint'($signed(VEC[k][31:16])), longint'($signed(VEC[k][15:0])),
              (k == 1 || k == 10) ? "R3 R2 repeat gives zero" :
              (k == 7 || k == 8)  ? "R6 clamp" : "R1 cross product", got);
      end

      // R2: long idle with junk, then a repeat must give exact zero
      send(-1234, 4321, "R1 cross product", got);
      repeat (20) begin
         @(negedge clk); in_i = 16'($urandom); in_q = 16'($urandom);
      end
      send(-1234, 4321, "R2 idle inputs ignored", got);
      check("R2 idle inputs ignored", got, 0);

      // R1: rounding tie cases, y = +16384 and y = -16384
      send(1, 0, "R1 cross product", got);       // history (1,0)
      send(1, 16384, "R1 half rounds up", got);
      check("R1 half rounds up", got, 1);
      send(1, 0, "R1 cross product", got);
      send(1, -16384, "R1 minus half rounds up", got);
      check("R1 minus half rounds up", got, 0);

      // R5: three back-to-back strobes
      sv_i = '{300, -9000, 25000};
      sv_q = '{-7000, 12000, 4000};
      for (int j = 0; j < 3; j++) model(sv_i[j], sv_q[j], exps[j]);
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         if (j >= 3) begin
            check("R5 streamed strobe", longint'(out_valid), 1);
            check("R5 streamed data", longint'(out_data), exps[j-3]);
         end
         if (j < 3) begin
            in_valid = 1'b1; in_i = 16'(sv_i[j]); in_q = 16'(sv_q[j]);
         end else begin
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      check("R5 strobe ends", longint'(out_valid), 0);

      // R4, R7: reset mid-run brings back the zero history and the marker
      do_reset();
      send(500, -700, "R4 zero history", got);
      send(600, -600, "R1 cross product", got);

      // R8: 5 kHz tone, 20 kHz peak deviation, 400 kHz rate
      ph = 0.0;
      for (int n = 0; n < 160; n++) begin
         m = $sin(2.0 * 3.14159265358979 * 5000.0 * n / 400000.0);
         ph = ph + 2.0 * 3.14159265358979 * 20000.0 / 400000.0 * m;
         send(longint'($rtoi(20000.0 * $cos(ph))), longint'($rtoi(20000.0 * $sin(ph))),
              "R1 tone sample", got);
         if (n >= 2 && m > 0.3)  check("R8 tone positive", longint'(got > 0), 1);
         if (n >= 2 && m < -0.3) check("R8 tone negative", longint'(got < 0), 1);
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

endmodule